// File: doc/BRIEF.md
# Sound Generator Register Bridge

This block sits between a CPU I/O bus and the register file of a three-channel programmable sound generator. Software reaches it through two port maps that share one index latch and one data path. The first map uses full 16-bit addresses. The second map matches on the low address byte only. Software first writes a register number to the select port. It then writes data to, or reads data from, the register that number picks. Register 14 is a general-purpose port. Its two low bits drive an I2C bus as open-drain lines, and reads of those bits return the sensed line levels.

The stored registers are exposed to a downstream tone, noise and envelope core. Channel parameters are presented in left, middle and right positions. A strap input places channel B or channel C in the middle position.

A small command state machine sequences every access. A one-cycle bus strobe is decoded into a command. The command moves the machine to ST_SELECT, ST_STORE or ST_FETCH on the next edge. Any other strobe moves it to ST_IDLE. The action is committed on the edge after that, and the next state again follows the command decoded in that cycle. Every transition is therefore one of four: to ST_IDLE (no decoded access), to ST_SELECT (select write), to ST_STORE (data write) and to ST_FETCH (select-port read). Strobes may arrive in consecutive cycles, and their effects are committed in order.

Top module: `snd_reg_bridge`

## Requirements
- R1: After reset the index is 0 and all registers are 0. io_rdata is 0, io_rvalid is 0, env_restart is 0, all exposed fields are 0, and both I2C lines are released (sda_pull_low and scl_pull_low are 0).
- R2: A write strobe to address 0xFFFD, or to any address whose low byte is 0xF5, latches io_wdata[3:0] as the register index.
- R3: A write strobe to address 0xBFFD, or to any address whose low byte is 0xF6, stores io_wdata into the selected register. Registers 1, 3, 5 and 13 keep bits 3:0 and registers 6, 8, 9 and 10 keep bits 4:0; the unkept bits read as 0. All other registers keep all 8 bits.
- R4: A read strobe to 0xFFFD, or to a low byte of 0xF5, raises io_rvalid for one cycle, two clock edges after the strobe is sampled. io_rdata then carries the selected register, and io_rdata changes only in cycles where io_rvalid is high.
- R5: When the index is 15, data writes change no register and reads return 0xFF.
- R6: Strobes to any other address change no state and never raise io_rvalid.
- R7: Strobes in consecutive cycles are committed in order. A read strobe in the cycle right after a write returns the newly written value.
- R8: sda_pull_low is high exactly when register 7 bit 6 is 1 and register 14 bit 0 is 0. scl_pull_low follows the same rule with register 14 bit 1.
- R9: A read of register 14 returns the stored bits 7:2. Bit 1 carries the sensed SCL level and bit 0 the sensed SDA level, taken through a two-flop synchroniser.
- R10: Channel A uses tone period {reg1[3:0], reg0}, channel B uses {reg3[3:0], reg2} and channel C uses {reg5[3:0], reg4}. Amplitudes are reg8, reg9 and reg10 bits 4:0. In register 7, bits 0 to 2 are the tone enables and bits 3 to 5 the noise enables for A, B and C, and a 0 bit means enabled. With stereo_acb at 0, left is A, middle is B and right is C. With stereo_acb at 1, the middle position carries C and the right position carries B.
- R11: noise_period is reg6[4:0], env_period is {reg12, reg11} and env_shape is reg13[3:0]. env_restart is high for one cycle, in the same cycle that a store into register 13 becomes visible.
- R12: If write and read strobes are high together, only the write is decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 16 | I/O address of the current strobe |
| io_wr | input | 1 | One-cycle write strobe |
| io_rd | input | 1 | One-cycle read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, held between reads |
| io_rvalid | output | 1 | Read data valid pulse |
| stereo_acb | input | 1 | 0: B in the middle position, 1: C in the middle position |
| sda_in | input | 1 | Sensed SDA line level |
| scl_in | input | 1 | Sensed SCL line level |
| sda_pull_low | output | 1 | Drive SDA low |
| scl_pull_low | output | 1 | Drive SCL low |
| left_period | output | 12 | Tone period, left position |
| mid_period | output | 12 | Tone period, middle position |
| right_period | output | 12 | Tone period, right position |
| left_amp | output | 5 | Amplitude, left position |
| mid_amp | output | 5 | Amplitude, middle position |
| right_amp | output | 5 | Amplitude, right position |
| left_tone_on | output | 1 | Tone enabled, left position |
| mid_tone_on | output | 1 | Tone enabled, middle position |
| right_tone_on | output | 1 | Tone enabled, right position |
| left_noise_on | output | 1 | Noise enabled, left position |
| mid_noise_on | output | 1 | Noise enabled, middle position |
| right_noise_on | output | 1 | Noise enabled, right position |
| noise_period | output | 5 | Noise period |
| env_period | output | 16 | Envelope period |
| env_shape | output | 4 | Envelope shape |
| env_restart | output | 1 | Pulse when the shape register is written |

## Verification
Because strobes can arrive in back-to-back cycles, two things can fall in the same cycle. One is the commit of a store (or a select) in ST_STORE or ST_SELECT. The other is the capture of the next read strobe into ST_FETCH. The bench provokes this by issuing a write and then a read on consecutive cycles. The scoreboard expects the fresh value, not the stale one. A second overlap arises when a register 14 read is captured while another bus device holds SDA low against a released line. The bench judges this by expecting the sensed level in bit 0, not the stored one.

// File: rtl/snd_bridge_pkg.sv
package snd_bridge_pkg;
    localparam int unsigned DW        = 8;
    localparam int unsigned AW        = 16;
    localparam int unsigned IW        = 4;
    localparam int unsigned REG_COUNT = 15;
    localparam int unsigned CH_COUNT  = 3;
    localparam int unsigned PER_W     = 12;
    localparam int unsigned AMP_W     = 5;

    localparam logic [AW-1:0] WIDE_SEL_ADDR   = 16'hFFFD;
    localparam logic [AW-1:0] WIDE_DAT_ADDR   = 16'hBFFD;
    localparam logic [7:0]    NARROW_SEL_ADDR = 8'hF5;
    localparam logic [7:0]    NARROW_DAT_ADDR = 8'hF6;

    localparam int unsigned NOISE_REG  = 6;
    localparam int unsigned MIX_REG    = 7;
    localparam int unsigned AMP_BASE   = 8;
    localparam int unsigned ENV_LO     = 11;
    localparam int unsigned ENV_HI     = 12;
    localparam int unsigned SHAPE_REG  = 13;
    localparam int unsigned IO_REG     = 14;
    localparam int unsigned IO_DIR_BIT = 6;

    localparam logic [DW-1:0] VOID_READ = 8'hFF;

    typedef enum logic [1:0] {
        CMD_NONE,
        CMD_SELECT,
        CMD_STORE,
        CMD_FETCH
    } cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SELECT,
        ST_STORE,
        ST_FETCH
    } state_e;

    // Bits each register keeps; the rest read as zero.
    function automatic logic [DW-1:0] field_mask(input int unsigned idx);
        case (idx)
            1, 3, 5, 13:  return 8'h0F;
            6, 8, 9, 10:  return 8'h1F;
            default:      return 8'hFF;
        endcase
    endfunction
endpackage

// File: rtl/snd_port_decode.sv
module snd_port_decode
    import snd_bridge_pkg::*;
(
    input  logic [AW-1:0] addr,
    input  logic          wr,
    input  logic          rd,
    output cmd_e          cmd
);
    logic sel_hit;
    logic dat_hit;

    always_comb begin
        sel_hit = (addr == WIDE_SEL_ADDR) || (addr[7:0] == NARROW_SEL_ADDR);
        dat_hit = (addr == WIDE_DAT_ADDR) || (addr[7:0] == NARROW_DAT_ADDR);
        cmd     = CMD_NONE;
        if (wr) begin
            // a write strobe always wins over a simultaneous read
            if (sel_hit)      cmd = CMD_SELECT;
            else if (dat_hit) cmd = CMD_STORE;
        end else if (rd && sel_hit) begin
            cmd = CMD_FETCH;
        end
    end
endmodule

// File: rtl/snd_line_sync.sv
module snd_line_sync #(
    parameter int unsigned LINES  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] line_i,
    output logic [LINES-1:0] line_o
);
    for (genvar l = 0; l < LINES; l++) begin : g_line
        logic [STAGES-1:0] shift_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) shift_q <= '1;
            else        shift_q <= {shift_q[STAGES-2:0], line_i[l]};
        end
        assign line_o[l] = shift_q[STAGES-1];
    end
endmodule

// File: rtl/snd_regfile.sv
module snd_regfile
    import snd_bridge_pkg::*;
#(
    parameter int unsigned REGS = REG_COUNT
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [IW-1:0]            widx,
    input  logic [DW-1:0]            wdata,
    output logic [REGS-1:0][DW-1:0]  regs_o
);
    for (genvar g = 0; g < REGS; g++) begin : g_reg
        localparam logic [DW-1:0] KEEP = field_mask(g);
        logic [DW-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          q <= '0;
            else if (we && (widx == IW'(g)))     q <= wdata & KEEP;
        end
        assign regs_o[g] = q;
    end
endmodule

// File: rtl/snd_stereo_route.sv
module snd_stereo_route
    import snd_bridge_pkg::*;
(
    input  logic                            acb,
    input  logic [CH_COUNT-1:0][PER_W-1:0]  period_i,
    input  logic [CH_COUNT-1:0][AMP_W-1:0]  amp_i,
    input  logic [CH_COUNT-1:0]             tone_i,
    input  logic [CH_COUNT-1:0]             noise_i,
    output logic [CH_COUNT-1:0][PER_W-1:0]  period_o,
    output logic [CH_COUNT-1:0][AMP_W-1:0]  amp_o,
    output logic [CH_COUNT-1:0]             tone_o,
    output logic [CH_COUNT-1:0]             noise_o
);
    // position p takes channel p, except that the two outer-right
    // positions trade places in the alternate order
    for (genvar p = 0; p < CH_COUNT; p++) begin : g_pos
        localparam int unsigned SWAP = (p == 1) ? 2 : ((p == 2) ? 1 : p);
        assign period_o[p] = acb ? period_i[SWAP] : period_i[p];
        assign amp_o[p]    = acb ? amp_i[SWAP]    : amp_i[p];
        assign tone_o[p]   = acb ? tone_i[SWAP]   : tone_i[p];
        assign noise_o[p]  = acb ? noise_i[SWAP]  : noise_i[p];
    end
endmodule

// File: rtl/snd_reg_bridge.sv
module snd_reg_bridge
    import snd_bridge_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] io_addr,
    input  logic        io_wr,
    input  logic        io_rd,
    input  logic [7:0]  io_wdata,
    output logic [7:0]  io_rdata,
    output logic        io_rvalid,
    input  logic        stereo_acb,
    input  logic        sda_in,
    input  logic        scl_in,
    output logic        sda_pull_low,
    output logic        scl_pull_low,
    output logic [11:0] left_period,
    output logic [11:0] mid_period,
    output logic [11:0] right_period,
    output logic [4:0]  left_amp,
    output logic [4:0]  mid_amp,
    output logic [4:0]  right_amp,
    output logic        left_tone_on,
    output logic        mid_tone_on,
    output logic        right_tone_on,
    output logic        left_noise_on,
    output logic        mid_noise_on,
    output logic        right_noise_on,
    output logic [4:0]  noise_period,
    output logic [15:0] env_period,
    output logic [3:0]  env_shape,
    output logic        env_restart
);
    cmd_e                          cmd;
    state_e                        state_q;
    state_e                        state_d;
    logic [DW-1:0]                 cap_q;
    logic [IW-1:0]                 idx_q;
    logic [DW-1:0]                 rdata_q;
    logic                          rvalid_q;
    logic                          restart_q;
    logic                          store_en;
    logic [DW-1:0]                 raw_val;
    logic [DW-1:0]                 rd_val;
    logic [1:0]                    line_s;
    logic [REG_COUNT-1:0][DW-1:0]  regs;

    logic [CH_COUNT-1:0][PER_W-1:0] ch_period;
    logic [CH_COUNT-1:0][AMP_W-1:0] ch_amp;
    logic [CH_COUNT-1:0]            ch_tone;
    logic [CH_COUNT-1:0]            ch_noise;
    logic [CH_COUNT-1:0][PER_W-1:0] pos_period;
    logic [CH_COUNT-1:0][AMP_W-1:0] pos_amp;
    logic [CH_COUNT-1:0]            pos_tone;
    logic [CH_COUNT-1:0]            pos_noise;

    snd_port_decode u_decode (
        .addr (io_addr),
        .wr   (io_wr),
        .rd   (io_rd),
        .cmd  (cmd)
    );

    // Next state follows the command decoded this cycle.
    always_comb begin
        unique case (cmd)
            CMD_NONE:   state_d = ST_IDLE;
            CMD_SELECT: state_d = ST_SELECT;
            CMD_STORE:  state_d = ST_STORE;
            CMD_FETCH:  state_d = ST_FETCH;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cap_q   <= '0;
        end else begin
            state_q <= state_d;
            cap_q   <= io_wdata;
        end
    end

    // Actions committed by the state that was entered on the last edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q     <= '0;
            rdata_q   <= '0;
            rvalid_q  <= 1'b0;
            restart_q <= 1'b0;
        end else begin
            rvalid_q  <= 1'b0;
            restart_q <= 1'b0;
            unique case (state_q)
                ST_IDLE:   ;
                ST_SELECT: idx_q <= cap_q[IW-1:0];
                ST_STORE:  restart_q <= (idx_q == IW'(SHAPE_REG));
                ST_FETCH: begin
                    rdata_q  <= rd_val;
                    rvalid_q <= 1'b1;
                end
            endcase
        end
    end

    assign store_en = (state_q == ST_STORE) && (idx_q < IW'(REG_COUNT));

    snd_regfile #(
        .REGS (REG_COUNT)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (store_en),
        .widx   (idx_q),
        .wdata  (cap_q),
        .regs_o (regs)
    );

    snd_line_sync #(
        .LINES  (2),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i ({scl_in, sda_in}),
        .line_o (line_s)
    );

    always_comb begin
        raw_val = VOID_READ;
        for (int i = 0; i < REG_COUNT; i++) begin
            if (idx_q == IW'(i)) raw_val = regs[i];
        end
        if (idx_q == IW'(IO_REG)) rd_val = {raw_val[7:2], line_s};
        else                      rd_val = raw_val;
    end

    assign io_rdata  = rdata_q;
    assign io_rvalid = rvalid_q;

    assign sda_pull_low = regs[MIX_REG][IO_DIR_BIT] & ~regs[IO_REG][0];
    assign scl_pull_low = regs[MIX_REG][IO_DIR_BIT] & ~regs[IO_REG][1];

    for (genvar c = 0; c < CH_COUNT; c++) begin : g_chan
        assign ch_period[c] = {regs[2*c+1][3:0], regs[2*c]};
        assign ch_amp[c]    = regs[AMP_BASE+c][AMP_W-1:0];
        assign ch_tone[c]   = ~regs[MIX_REG][c];
        assign ch_noise[c]  = ~regs[MIX_REG][CH_COUNT+c];
    end

    snd_stereo_route u_route (
        .acb      (stereo_acb),
        .period_i (ch_period),
        .amp_i    (ch_amp),
        .tone_i   (ch_tone),
        .noise_i  (ch_noise),
        .period_o (pos_period),
        .amp_o    (pos_amp),
        .tone_o   (pos_tone),
        .noise_o  (pos_noise)
    );

    assign left_period    = pos_period[0];
    assign mid_period     = pos_period[1];
    assign right_period   = pos_period[2];
    assign left_amp       = pos_amp[0];
    assign mid_amp        = pos_amp[1];
    assign right_amp      = pos_amp[2];
    assign left_tone_on   = pos_tone[0];
    assign mid_tone_on    = pos_tone[1];
    assign right_tone_on  = pos_tone[2];
    assign left_noise_on  = pos_noise[0];
    assign mid_noise_on   = pos_noise[1];
    assign right_noise_on = pos_noise[2];

    assign noise_period = regs[NOISE_REG][4:0];
    assign env_period   = {regs[ENV_HI], regs[ENV_LO]};
    assign env_shape    = regs[SHAPE_REG][3:0];
    assign env_restart  = restart_q;
endmodule

// File: rtl/snd_reg_bridge_chk.sv
module snd_reg_bridge_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] io_addr,
    input logic        io_wr,
    input logic        io_rd,
    input logic [7:0]  io_rdata,
    input logic        io_rvalid,
    input logic        sda_pull_low,
    input logic        scl_pull_low,
    input logic        env_restart
);
    logic read_sel;
    assign read_sel = io_rd && !io_wr &&
                      ((io_addr == 16'hFFFD) || (io_addr[7:0] == 8'hF5));

    AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        read_sel |-> ##2 io_rvalid); // R4

    AST_RDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !io_rvalid |-> $stable(io_rdata)); // R4

    AST_NO_STRAY_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
        io_rvalid |-> $past(io_rd, 2)); // R6

    AST_SDA_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull_low) |-> $past(io_wr, 2)); // R8

    AST_SCL_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(scl_pull_low) |-> $past(io_wr, 2)); // R8

    AST_RESTART_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        env_restart |-> $past(io_wr, 2)); // R11
endmodule

bind snd_reg_bridge snd_reg_bridge_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .io_addr      (io_addr),
    .io_wr        (io_wr),
    .io_rd        (io_rd),
    .io_rdata     (io_rdata),
    .io_rvalid    (io_rvalid),
    .sda_pull_low (sda_pull_low),
    .scl_pull_low (scl_pull_low),
    .env_restart  (env_restart)
);

// File: tb/snd_reg_bridge_bench.sv
module snd_reg_bridge_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        io_rvalid;
    logic        stereo_acb = 1'b0;
    logic        ext_sda_low = 1'b0;
    logic        ext_scl_low = 1'b0;
    logic        sda_line, scl_line;
    logic        sda_pull_low, scl_pull_low;
    logic [11:0] left_period, mid_period, right_period;
    logic [4:0]  left_amp, mid_amp, right_amp;
    logic        left_tone_on, mid_tone_on, right_tone_on;
    logic        left_noise_on, mid_noise_on, right_noise_on;
    logic [4:0]  noise_period;
    logic [15:0] env_period;
    logic [3:0]  env_shape;
    logic        env_restart;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    // open-drain bus with pull-ups
    assign sda_line = ~sda_pull_low & ~ext_sda_low;
    assign scl_line = ~scl_pull_low & ~ext_scl_low;

    snd_reg_bridge u_snd_reg_bridge (
        .clk, .rst_n, .io_addr, .io_wr, .io_rd, .io_wdata, .io_rdata, .io_rvalid,
        .stereo_acb, .sda_in(sda_line), .scl_in(scl_line),
        .sda_pull_low, .scl_pull_low,
        .left_period, .mid_period, .right_period,
        .left_amp, .mid_amp, .right_amp,
        .left_tone_on, .mid_tone_on, .right_tone_on,
        .left_noise_on, .mid_noise_on, .right_noise_on,
        .noise_period, .env_period, .env_shape, .env_restart
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: pops one expected item per read response
    always @(negedge clk) begin
        if (rst_n && io_rvalid && !done) begin
            vectors++;
            if (exp_q.size() == 0) begin
                miscompares++;
                $display("FAIL R6 actual=%0h expected=no response", io_rdata);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (io_rdata !== e) begin
                    miscompares++;
                    $display("FAIL %s actual=%0h expected=%0h", t, io_rdata, e);
                end
            end
        end
    end

    // called at a falling edge; returns at the next falling edge
    task automatic strobe(input logic w, input logic r, input logic [15:0] a, input logic [7:0] d);
        io_wr = w; io_rd = r; io_addr = a; io_wdata = d;
        @(negedge clk);
        io_wr = 1'b0; io_rd = 1'b0;
    endtask

    task automatic expect_read(input logic [15:0] a, input logic [7:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        strobe(1'b0, 1'b1, a, 8'h00);
    endtask

    task automatic wr_reg(input logic [3:0] idx, input logic [7:0] d);
        strobe(1'b1, 1'b0, 16'hFFFD, {4'h0, idx});
        strobe(1'b1, 1'b0, 16'hBFFD, d);
    endtask

    task automatic rd_reg(input logic [3:0] idx, input logic [7:0] e, input string t);
        strobe(1'b1, 1'b0, 16'hFFFD, {4'h0, idx});
        expect_read(16'hFFFD, e, t);
    endtask

    task automatic settle;
        repeat (3) @(negedge clk);
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            vectors++;
            miscompares++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 rdata", 32'(io_rdata), 0);
        chk("R1 rvalid", 32'(io_rvalid), 0);
        chk("R1 lines", {30'd0, sda_pull_low, scl_pull_low}, 0);
        chk("R1 fields", {left_period, env_period, noise_period}, 0);
        rd_reg(4'd0, 8'h00, "R1 reg0");
        settle();

        // R2 R3 R4 wide map
        wr_reg(4'd0, 8'hA5);
        rd_reg(4'd0, 8'hA5, "R3 wide store");
        settle();
        // R2 narrow map with arbitrary high byte, R3 masking
        strobe(1'b1, 1'b0, 16'h12F5, 8'h01);
        strobe(1'b1, 1'b0, 16'h34F6, 8'hFF);
        expect_read(16'h56F5, 8'h0F, "R2 narrow select / R3 mask reg1");
        settle();
        wr_reg(4'd6, 8'hFF);
        rd_reg(4'd6, 8'h1F, "R3 mask reg6");
        wr_reg(4'd8, 8'hEE);
        rd_reg(4'd8, 8'h0E, "R3 mask reg8");
        settle();

        // R5 index 15
        wr_reg(4'd15, 8'h77);
        expect_read(16'hFFFD, 8'hFF, "R5 void read");
        settle();
        rd_reg(4'd0, 8'hA5, "R5 reg0 untouched");
        settle();

        // R6 other addresses: select 0 now, stray select must not move it
        strobe(1'b1, 1'b0, 16'hFFFD, 8'h00);
        strobe(1'b1, 1'b0, 16'h7FFD, 8'h03);
        strobe(1'b1, 1'b0, 16'h3FFD, 8'h11);
        strobe(1'b0, 1'b1, 16'hBFFD, 8'h00);
        @(negedge clk);
        chk("R6 no rvalid", 32'(io_rvalid), 0);
        expect_read(16'hFFFD, 8'hA5, "R6 index and data unchanged");
        settle();

        // R7 back-to-back select, store, read
        strobe(1'b1, 1'b0, 16'hFFFD, 8'h02);
        strobe(1'b1, 1'b0, 16'hBFFD, 8'h3C);
        expect_read(16'hFFFD, 8'h3C, "R7 read after write");
        strobe(1'b1, 1'b0, 16'h00F6, 8'hC3);
        expect_read(16'h00F5, 8'hC3, "R7 second read after write");
        settle();

        // R8 I2C drive
        wr_reg(4'd7, 8'h40);
        @(negedge clk);
        chk("R8 both pulled", {30'd0, sda_pull_low, scl_pull_low}, 32'h3);
        wr_reg(4'd14, 8'h01);
        @(negedge clk);
        chk("R8 sda released", {30'd0, sda_pull_low, scl_pull_low}, 32'h1);
        wr_reg(4'd7, 8'h00);
        @(negedge clk);
        chk("R8 input mode released", {30'd0, sda_pull_low, scl_pull_low}, 0);

        // R9 sensed levels
        wr_reg(4'd7, 8'h40);
        wr_reg(4'd14, 8'hFD);
        ext_sda_low = 1'b1;
        settle();
        rd_reg(4'd14, 8'hFC, "R9 sda held by other device");
        settle();
        ext_sda_low = 1'b0;
        settle();
        rd_reg(4'd14, 8'hFD, "R9 sda released");
        settle();

        // R10 stereo routing
        wr_reg(4'd0, 8'h23); wr_reg(4'd1, 8'h01);
        wr_reg(4'd2, 8'h56); wr_reg(4'd3, 8'h04);
        wr_reg(4'd4, 8'h89); wr_reg(4'd5, 8'h07);
        wr_reg(4'd8, 8'h03); wr_reg(4'd9, 8'h05); wr_reg(4'd10, 8'h07);
        wr_reg(4'd7, 8'h4A);
        @(negedge clk);
        chk("R10 ABC periods", {left_period, mid_period, right_period}, 36'h123_456_789);
        chk("R10 ABC amps", {17'd0, left_amp, mid_amp, right_amp}, {17'd0, 5'd3, 5'd5, 5'd7});
        chk("R10 ABC enables", {26'd0, left_tone_on, mid_tone_on, right_tone_on,
                                left_noise_on, mid_noise_on, right_noise_on}, 32'b101_011);
        stereo_acb = 1'b1;
        @(negedge clk);
        chk("R10 ACB periods", {left_period, mid_period, right_period}, 36'h123_789_456);
        chk("R10 ACB amps", {17'd0, left_amp, mid_amp, right_amp}, {17'd0, 5'd3, 5'd7, 5'd5});
        chk("R10 ACB enables", {26'd0, left_tone_on, mid_tone_on, right_tone_on,
                                left_noise_on, mid_noise_on, right_noise_on}, 32'b110_011);
        stereo_acb = 1'b0;

        // R11 envelope and noise fields
        wr_reg(4'd11, 8'h34);
        wr_reg(4'd12, 8'h12);
        @(negedge clk);
        chk("R11 no restart on period", 32'(env_restart), 0);
        strobe(1'b1, 1'b0, 16'hFFFD, 8'h0D);
        strobe(1'b1, 1'b0, 16'hBFFD, 8'hFE);
        chk("R11 restart not early", 32'(env_restart), 0);
        @(negedge clk);
        chk("R11 restart pulse", 32'(env_restart), 1);
        chk("R11 shape", 32'(env_shape), 32'hE);
        @(negedge clk);
        chk("R11 restart ends", 32'(env_restart), 0);
        chk("R11 periods", {11'd0, env_period, noise_period}, {11'd0, 16'h1234, 5'h1F});

        // R12 write wins over read
        strobe(1'b1, 1'b1, 16'hFFFD, 8'h06);
        @(negedge clk);
        chk("R12 no rvalid", 32'(io_rvalid), 0);
        expect_read(16'hFFFD, 8'h1F, "R12 select taken");
        settle();

        chk("R4 all reads answered", 32'(exp_q.size()), 0);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule